// File: doc/BRIEF.md
# Receive Data Path with Byte-Lane Rotator

This block carries inbound words from a bus-side clock domain to a back-end that runs on its own user clock, which need not be related to the bus clock. Three independent receive queues sit between the domains: two for DMA traffic and one for target-write traffic. Each queue is a dual-clock FIFO whose pointers cross the boundary in Gray code through two-flop synchronizers.

On the back-end side a single 64-bit output bus is shared by the three queues. A source selector chooses which queue a read strobe pops. The word popped passes through a circular byte-lane rotator before it is registered onto the output, so the back-end can realign or compact data without extra logic. The two DMA queues also report empty and almost-empty. Each almost-empty threshold sits in a small register that the back-end writes.

A back-end consumer watches the flags, picks a source, sets the rotation and strobes a read on each cycle it wants a word. A new word can be taken on every user-clock cycle.

Top module: `rx_lane_path`

## Requirements
- R1: `src_sel` selects the queue popped by `rd_en`: 0 = DMA queue 0, 1 = DMA queue 1, 2 = target queue. Value 3 selects nothing, so a strobe with it pops no queue and leaves `rd_valid` low.
- R2: When `rd_en` is high and the selected queue is not empty at a `user_clk` edge, `rd_valid` is high for the following cycle and `rd_data` holds that queue's oldest word. Reads may occur on consecutive cycles with no gaps. `rd_data` keeps its value on cycles where `rd_valid` is low.
- R3: A strobe aimed at an empty queue is ignored: `rd_valid` stays low, `rd_data` is unchanged, and the queue's later contents and order are unaffected.
- R4: With `byte_select` = N, output byte k (bits 8k+7..8k) equals byte (k+N) mod 8 of the popped word. For example, word 0x0706050403020100 read with N=3 gives 0x0201000706050403.
- R5: With `byte_select` = 0, every byte leaves in the same lane it entered.
- R6: Each queue returns its words in write order and is independent of the others.
- R7: `dma_empty[i]` and `tgt_empty` are high exactly when the queue holds no word visible to the user domain. Pops update them on the next cycle. Writes reach them a few user cycles later through the synchronizer.
- R8: `dma_aempty[i]` is high when the occupancy of DMA queue i is at or below its threshold. The threshold of each queue is 2 after reset.
- R9: A `user_clk` edge with `cfg_wr` high loads `cfg_data` into the threshold of DMA queue `cfg_sel` (0 or 1). The new threshold governs `dma_aempty` from the next cycle.
- R10: Each queue holds 16 words. `wr_full[i]` rises once 16 words are held. A push while full is dropped, and the stored 16 words are still read back intact.
- R11: After reset: all empty and almost-empty flags are high, `wr_full` is 0, `rd_valid` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Bus-side write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_push | input | 3 | Per-queue push strobe (bit 0 DMA0, bit 1 DMA1, bit 2 target) |
| wr_data | input | 64 | Word written by a push |
| wr_full | output | 3 | Per-queue full flag, write domain |
| user_clk | input | 1 | Back-end clock |
| user_rst_n | input | 1 | Asynchronous active-low reset, user domain |
| rd_en | input | 1 | Read strobe |
| src_sel | input | 2 | Queue selector for the read strobe |
| byte_select | input | 3 | Rotation amount in byte lanes |
| rd_valid | output | 1 | Output word was popped in the previous cycle |
| rd_data | output | 64 | Rotated output word |
| dma_empty | output | 2 | Empty flags of DMA queues 0 and 1 |
| dma_aempty | output | 2 | Almost-empty flags of DMA queues 0 and 1 |
| tgt_empty | output | 1 | Empty flag of the target queue |
| cfg_wr | input | 1 | Threshold register write strobe |
| cfg_sel | input | 1 | Which DMA threshold to write |
| cfg_data | input | 5 | Threshold value |

## Verification
The bench looks for the occupancy boundaries: exactly at the threshold and one above it, a threshold of zero, and a queue filled to 16 with a seventeenth push. A design off by one in the comparison, or one that wraps the write pointer on a full queue, shows a wrong flag or a wrong seventeenth word. Strobes on empty queues and on the unused selector value are interleaved with real reads. A design that moves its pointer anyway would return words out of order later or raise `rd_valid` spuriously. Rotation is driven through every select value on back-to-back reads, where a reversed direction or a stale select would corrupt the lanes.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int NQ = 3;

  typedef enum logic [1:0] {
    SRC_DMA0 = 2'd0,
    SRC_DMA1 = 2'd1,
    SRC_TGT  = 2'd2,
    SRC_NONE = 2'd3
  } rx_src_e;
endpackage

// File: rtl/rxl_rst_sync.sv
module rxl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/rxl_sync.sv
module rxl_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/rxl_afifo.sv
module rxl_afifo #(
  parameter int DW = 64,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW,
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic [PW-1:0] level
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return (b >> 1) ^ b;
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rgray_s, rbin_s;
  logic          push_ok;

  // read domain
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wgray_s, wbin_s;
  logic          pop_ok;

  rxl_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_s));
  rxl_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_s));

  always_comb begin
    rbin_s  = from_gray(rgray_s);
    full    = ((wbin_q - rbin_s) == PW'(DEPTH));
    push_ok = push && !full;
    wbin_d  = wbin_q + PW'(push_ok);
    wgray_d = to_gray(wbin_d);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push_ok) begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (push_ok) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_comb begin
    wbin_s  = from_gray(wgray_s);
    level   = wbin_s - rbin_q;
    empty   = (level == '0);
    pop_ok  = pop && !empty;
    rbin_d  = rbin_q + PW'(pop_ok);
    rgray_d = to_gray(rbin_d);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop_ok) begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign rdata = mem[rbin_q[AW-1:0]];
endmodule

// File: rtl/rxl_rotator.sv
module rxl_rotator #(
  parameter int DW = 64,
  localparam int LANES = DW / 8,
  localparam int SELW = $clog2(LANES)
) (
  input  logic [DW-1:0]   din,
  input  logic [SELW-1:0] shift,
  output logic [DW-1:0]   dout
);
  logic [7:0] lane_in [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_in[g] = din[g*8 +: 8];
  end

  // lane count is a power of two, so the index wraps by truncation
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SELW-1:0] src_idx;
    assign src_idx        = SELW'(k) + shift;
    assign dout[k*8 +: 8] = lane_in[src_idx];
  end
endmodule

// File: rtl/rx_lane_path.sv
module rx_lane_path
  import rxl_pkg::*;
#(
  parameter int DW = 64,
  parameter int AW = 4,
  localparam int LANES = DW / 8,
  localparam int SELW = $clog2(LANES),
  localparam int THRW = AW + 1
) (
  input  logic            wr_clk,
  input  logic            wr_rst_n,
  input  logic [NQ-1:0]   wr_push,
  input  logic [DW-1:0]   wr_data,
  output logic [NQ-1:0]   wr_full,
  input  logic            user_clk,
  input  logic            user_rst_n,
  input  logic            rd_en,
  input  logic [1:0]      src_sel,
  input  logic [SELW-1:0] byte_select,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [1:0]      dma_empty,
  output logic [1:0]      dma_aempty,
  output logic            tgt_empty,
  input  logic            cfg_wr,
  input  logic            cfg_sel,
  input  logic [THRW-1:0] cfg_data
);
  localparam logic [THRW-1:0] THR_RESET = THRW'(2);

  logic wr_srst_n, us_rst_n;

  rxl_rst_sync u_wrst (.clk(wr_clk),   .arst_n(wr_rst_n),   .srst_n(wr_srst_n));
  rxl_rst_sync u_urst (.clk(user_clk), .arst_n(user_rst_n), .srst_n(us_rst_n));

  logic [DW-1:0]   head  [NQ];
  logic [THRW-1:0] q_lvl [NQ];
  logic [NQ-1:0]   q_empty, q_pop;

  for (genvar g = 0; g < NQ; g++) begin : g_queue
    assign q_pop[g] = rd_en && (src_sel == 2'(g));

    rxl_afifo #(.DW(DW), .AW(AW)) u_fifo (
      .wclk  (wr_clk),
      .wrst_n(wr_srst_n),
      .push  (wr_push[g]),
      .wdata (wr_data),
      .full  (wr_full[g]),
      .rclk  (user_clk),
      .rrst_n(us_rst_n),
      .pop   (q_pop[g]),
      .rdata (head[g]),
      .empty (q_empty[g]),
      .level (q_lvl[g])
    );
  end

  // source selection
  logic [DW-1:0] sel_head, rot_data;
  logic          sel_empty, fire;

  always_comb begin
    sel_head  = '0;
    sel_empty = 1'b1;
    case (rx_src_e'(src_sel))
      SRC_DMA0: begin sel_head = head[0]; sel_empty = q_empty[0]; end
      SRC_DMA1: begin sel_head = head[1]; sel_empty = q_empty[1]; end
      SRC_TGT:  begin sel_head = head[2]; sel_empty = q_empty[2]; end
      default:  begin sel_head = '0;      sel_empty = 1'b1;       end
    endcase
    fire = rd_en && !sel_empty;
  end

  rxl_rotator #(.DW(DW)) u_rot (.din(sel_head), .shift(byte_select), .dout(rot_data));

  // output register
  logic          rd_valid_q, rd_valid_d;
  logic [DW-1:0] rd_data_q, rd_data_d;

  always_comb begin
    rd_valid_d = fire;
    rd_data_d  = fire ? rot_data : rd_data_q;
  end

  always_ff @(posedge user_clk or negedge us_rst_n) begin
    if (!us_rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      if (fire) rd_data_q <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // almost-empty thresholds for the two DMA queues
  logic [THRW-1:0] thr_q [2];
  logic [THRW-1:0] thr_d [2];
  logic [1:0]      thr_en;

  for (genvar g = 0; g < 2; g++) begin : g_thr
    assign thr_en[g] = cfg_wr && (cfg_sel == 1'(g));
    assign thr_d[g]  = cfg_data;

    always_ff @(posedge user_clk or negedge us_rst_n) begin
      if (!us_rst_n)     thr_q[g] <= THR_RESET;
      else if (thr_en[g]) thr_q[g] <= thr_d[g];
    end

    assign dma_aempty[g] = (q_lvl[g] <= thr_q[g]);
    assign dma_empty[g]  = q_empty[g];
  end

  assign tgt_empty = q_empty[2];
endmodule

// File: rtl/rx_lane_path_chk.sv
module rx_lane_path_chk #(
  parameter int DW = 64
) (
  input logic          user_clk,
  input logic          user_rst_n,
  input logic          rd_en,
  input logic [1:0]    src_sel,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic [1:0]    dma_empty,
  input logic [1:0]    dma_aempty,
  input logic          tgt_empty
);
  logic strobe_dead;
  assign strobe_dead = rd_en && ((src_sel == 2'd0 && dma_empty[0]) ||
                                 (src_sel == 2'd1 && dma_empty[1]) ||
                                 (src_sel == 2'd2 && tgt_empty)    ||
                                 (src_sel == 2'd3));

  // R3 and R1: a strobe that cannot pop yields no word
  a_r3_dead_strobe: assert property (@(posedge user_clk) disable iff (!user_rst_n)
    strobe_dead |=> !rd_valid);

  // R2: a word only follows a strobe
  a_r2_valid_after_strobe: assert property (@(posedge user_clk) disable iff (!user_rst_n)
    rd_valid |-> $past(rd_en));

  // R2: output held when no word arrives
  a_r2_data_held: assert property (@(posedge user_clk) disable iff (!user_rst_n)
    !rd_valid |-> $stable(rd_data));

  // R8: an empty DMA queue is also almost empty
  a_r8_empty_aempty0: assert property (@(posedge user_clk) disable iff (!user_rst_n)
    dma_empty[0] |-> dma_aempty[0]);

  a_r8_empty_aempty1: assert property (@(posedge user_clk) disable iff (!user_rst_n)
    dma_empty[1] |-> dma_aempty[1]);
endmodule

bind rx_lane_path rx_lane_path_chk #(.DW(DW)) u_chk (
  .user_clk  (user_clk),
  .user_rst_n(user_rst_n),
  .rd_en     (rd_en),
  .src_sel   (src_sel),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .dma_empty (dma_empty),
  .dma_aempty(dma_aempty),
  .tgt_empty (tgt_empty)
);

// File: tb/rx_lane_path_tb.sv
`timescale 1ns/1ps
module rx_lane_path_tb;
  logic        wr_clk = 1'b0, user_clk = 1'b0;
  logic        wr_rst_n = 1'b0, user_rst_n = 1'b0;
  logic [2:0]  wr_push = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  wr_full;
  logic        rd_en = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [2:0]  byte_select = 3'd0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [1:0]  dma_empty, dma_aempty;
  logic        tgt_empty;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [4:0]  cfg_data = '0;

  always #5   user_clk = ~user_clk;
  always #3.5 wr_clk   = ~wr_clk;

  rx_lane_path u_dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit settled = 1'b0;

  // reference model
  logic [63:0] mq0[$], mq1[$], mq2[$];
  int          thr_m [2];
  logic        exp_valid;
  logic [63:0] exp_data;

  function automatic int qsize(input int i);
    if (i == 0) return mq0.size();
    if (i == 1) return mq1.size();
    return mq2.size();
  endfunction

  function automatic logic [63:0] qpop(input int i);
    if (i == 0) return mq0.pop_front();
    if (i == 1) return mq1.pop_front();
    return mq2.pop_front();
  endfunction

  function automatic void qpush(input int i, input logic [63:0] d);
    if (i == 0) mq0.push_back(d);
    else if (i == 1) mq1.push_back(d);
    else mq2.push_back(d);
  endfunction

  function automatic logic [63:0] rotate(input logic [63:0] w, input int n);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = w[8*((k + n) % 8) +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge user_clk or negedge user_rst_n) begin
    if (!user_rst_n) begin
      exp_valid = 1'b0;
      exp_data  = '0;
      thr_m[0]  = 2;
      thr_m[1]  = 2;
    end else begin
      if (rd_en && src_sel != 2'd3 && qsize(int'(src_sel)) > 0) begin
        exp_valid = 1'b1;
        exp_data  = rotate(qpop(int'(src_sel)), int'(byte_select));
      end else begin
        exp_valid = 1'b0;
      end
      if (cfg_wr) thr_m[cfg_sel] = int'(cfg_data);
    end
  end

  always @(negedge user_clk) begin
    if (settled) begin
      check(rd_valid == exp_valid, "R2 rd_valid", 64'(rd_valid), 64'(exp_valid));
      if (exp_valid) check(rd_data == exp_data, "R6 rd_data order/lanes", rd_data, exp_data);
      for (int i = 0; i < 2; i++) begin
        check(dma_empty[i] == (qsize(i) == 0), "R7 dma_empty", 64'(dma_empty[i]), 64'(qsize(i) == 0));
        check(dma_aempty[i] == (qsize(i) <= thr_m[i]), "R8 dma_aempty",
              64'(dma_aempty[i]), 64'(qsize(i) <= thr_m[i]));
      end
      check(tgt_empty == (qsize(2) == 0), "R7 tgt_empty", 64'(tgt_empty), 64'(qsize(2) == 0));
    end
  end

  task automatic push(input int q, input logic [63:0] d);
    @(negedge wr_clk);
    wr_push    = '0;
    wr_push[q] = 1'b1;
    wr_data    = d;
    if (qsize(q) < 16) qpush(q, d);
    @(negedge wr_clk);
    wr_push = '0;
  endtask

  task automatic settle();
    repeat (6) @(negedge user_clk);
    settled = 1'b1;
  endtask

  task automatic rd(input logic en, input logic [1:0] s, input logic [2:0] b);
    @(negedge user_clk);
    rd_en = en; src_sel = s; byte_select = b;
  endtask

  task automatic idle(input int n);
    rd(1'b0, 2'd0, 3'd0);
    repeat (n) @(negedge user_clk);
  endtask

  function automatic logic [63:0] pat(input int q, input int n);
    return (64'(n + 1) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(q) << 60);
  endfunction

  always @(posedge user_clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 50000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge user_clk);
    wr_rst_n = 1'b1; user_rst_n = 1'b1;
    repeat (5) @(negedge user_clk);
    settled = 1'b1;

    // R11: reset state
    check(dma_empty == 2'b11 && tgt_empty, "R11 empty after reset", {61'b0, dma_empty, tgt_empty}, 64'h7);
    check(dma_aempty == 2'b11, "R11 aempty after reset", 64'(dma_aempty), 64'h3);
    check(wr_full == 3'b000, "R11 wr_full after reset", 64'(wr_full), 64'h0);
    check(!rd_valid && rd_data == '0, "R11 output after reset", rd_data, 64'h0);

    // fill queues
    settled = 1'b0;
    for (int n = 0; n < 5; n++) push(0, pat(0, n));
    for (int n = 0; n < 3; n++) push(1, pat(1, n));
    push(2, 64'h0706050403020100);
    push(2, pat(2, 1));
    settle();
    check(dma_aempty[1] == 1'b0, "R8 level 3 above threshold 2", 64'(dma_aempty[1]), 64'h0);

    // R5: pass-through on queue 1, back-to-back
    rd(1'b1, 2'd1, 3'd0);
    rd(1'b0, 2'd1, 3'd0);
    @(negedge user_clk);
    check(rd_data == pat(1, 0), "R5 same lanes", rd_data, pat(1, 0));
    check(dma_aempty[1] == 1'b1, "R8 level 2 at threshold", 64'(dma_aempty[1]), 64'h1);
    rd(1'b1, 2'd1, 3'd0);
    rd(1'b1, 2'd1, 3'd0);
    // R3: queue 1 now empty; strobes ignored
    rd(1'b1, 2'd1, 3'd5);
    rd(1'b1, 2'd1, 3'd2);
    rd(1'b0, 2'd0, 3'd0);
    check(!rd_valid && rd_data == pat(1, 2), "R3 empty pop ignored", rd_data, pat(1, 2));

    // R1: selector 3 pops nothing
    rd(1'b1, 2'd3, 3'd0);
    rd(1'b1, 2'd3, 3'd1);
    rd(1'b0, 2'd0, 3'd0);
    check(!rd_valid, "R1 selector 3 idle", 64'(rd_valid), 64'h0);

    // R4: rotations on queue 0, back-to-back
    for (int b = 0; b < 5; b++) rd(1'b1, 2'd0, 3'(b));
    idle(2);

    // R4: explicit rotation value on target queue
    rd(1'b1, 2'd2, 3'd3);
    rd(1'b0, 2'd0, 3'd0);
    @(negedge user_clk);
    check(rd_data == 64'h0201000706050403, "R4 rotate by 3", rd_data, 64'h0201000706050403);
    rd(1'b1, 2'd2, 3'd7);
    idle(2);

    // R9: thresholds 7 and 0
    @(negedge user_clk); cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_data = 5'd7;
    @(negedge user_clk); cfg_sel = 1'b1; cfg_data = 5'd0;
    @(negedge user_clk); cfg_wr = 1'b0;
    settled = 1'b0;
    for (int n = 0; n < 4; n++) push(0, pat(0, 10 + n));
    push(1, pat(1, 10));
    settle();
    check(dma_aempty[0] == 1'b1, "R9 threshold 7 level 4", 64'(dma_aempty[0]), 64'h1);
    check(dma_aempty[1] == 1'b0, "R9 threshold 0 level 1", 64'(dma_aempty[1]), 64'h0);
    rd(1'b1, 2'd1, 3'd1);
    rd(1'b1, 2'd0, 3'd6);
    rd(1'b1, 2'd1, 3'd0);
    rd(1'b1, 2'd0, 3'd2);
    idle(2);

    // R10: fill target queue past capacity
    settled = 1'b0;
    for (int n = 0; n < 17; n++) push(2, pat(2, 20 + n));
    repeat (2) @(negedge wr_clk);
    check(wr_full[2] == 1'b1, "R10 full at 16", 64'(wr_full), 64'h4);
    settle();
    for (int n = 0; n < 16; n++) rd(1'b1, 2'd2, 3'(n));
    idle(3);
    check(tgt_empty == 1'b1, "R10 sixteen words then empty", 64'(tgt_empty), 64'h1);
    for (int n = 0; n < 2; n++) rd(1'b1, 2'd0, 3'd0);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule